// File: doc/BRIEF.md
# Program-Memory Bank Decoder

This block turns a CPU address in the upper part of the map (0x6000 to 0xFFFF) into the number of an 8KB program-memory page. Four page registers and a small set of control fields decide the translation. The page layout can be one 32KB page, two 16KB pages or four 8KB pages across 0x8000-0xFFFF. In each layout the top page is either pinned to the highest page or taken from page register 3. A two-bit outer field places the whole result in one of four 512KB regions. An optional 8KB window at 0x6000-0x7FFF also draws its page from register 3, scaled to match the active layout.

The CPU writes the registers through a simple write strobe with address and data. The lookup is combinational from the lookup address and the register state. The result is an 8KB page number, plus a hit flag that says whether the address maps into program memory at all. The memory array behind it and any work RAM sit outside the block.

Top module: `prg_bank_decoder`

## Requirements
- R1: After reset the page registers hold 0xFF and all control fields are 0. In that state every address from 0x8000 upward maps to page {2'b00, 4'hF, addr[14:13]}, and 0x6000-0x7FFF does not hit.
- R2: Layout field values 0 and 4 (control 0, bits 2:0) select one 32KB page. The 8KB page number is {outer, page32[3:0], addr[14:13]}.
- R3: Layout values 1 and 5 select 16KB pages. 0x8000-0xBFFF uses page register 1 bits 4:0, and 0xC000-0xFFFF uses the top page. The output is {outer, page16, addr[13]}. Every address with bit 15 set gives a hit.
- R4: Layout values 2, 3, 6 and 7 select 8KB pages. 0x8000, 0xA000 and 0xC000 use page registers 0, 1 and 2 (bits 5:0), and 0xE000 uses the top page. Values 3 and 7 behave exactly like 2 and 6.
- R5: For layout values 0-3 the top page is all ones (32KB: 0xF, 16KB: 0x1F, 8KB: 0x3F). For values 4-7 it is page register 3 masked to the page width.
- R6: Control 0 bit 7 enables the 0x6000-0x7FFF window. Its inner page is (reg3*4+3), (reg3*2+1) or reg3, masked to 6 bits, in the 32KB, 16KB and 8KB layouts respectively. When the bit is clear the window gives hit=0 and page 0.
- R7: Control 3 bits 2:1 form the outer field. It appears as bits 7:6 of every hitting page number.
- R8: A write with address 0x8000-0x8FFF loads page register addr[1:0]. A write with address 0xD000-0xD5FF loads control register addr[1:0], of which only controls 0 and 3 have an effect. Writes anywhere else, and to controls 1 and 2, change nothing.
- R9: Addresses below 0x6000 give hit=0 and page 0.
- R10: A register write takes effect at the clock edge that samples it. A lookup in the same cycle still sees the old value, and the lookup in the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| rdAddr | input | 16 | Address to translate |
| prgBank | output | 8 | 8KB page number: outer field over inner page |
| prgHit | output | 1 | Address maps into program memory |

## Verification
The two functions that can meet in one cycle are a register write and a lookup that depends on that same register. For example, page register 2 can be written while the lookup address sits at 0xC000 in an 8KB layout, or control 0 can be written while the lookup sits in the 0x6000 window. The bench sets up exactly these collisions. A behavioural model updates only on the clock edge and is compared against the outputs every cycle. It must agree that the collision cycle shows the old mapping and the following cycle the new one.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  localparam int ADDR_W  = 16;
  localparam int REG_CNT = 4;
  localparam int IDX_W   = $clog2(REG_CNT);

  // upper nibble of the write address that selects each register file
  localparam logic [3:0] PAGE_SPACE = 4'h8;
  localparam logic [3:0] CTL_SPACE  = 4'hD;
  localparam logic [3:0] CTL_LIMIT  = 4'h6;

  typedef enum logic [1:0] {
    SZ_32K = 2'd0,
    SZ_16K = 2'd1,
    SZ_8KA = 2'd2,
    SZ_8KB = 2'd3
  } pageSize_e;

  typedef struct packed {
    logic             pageWr;
    logic             ctlWr;
    logic [IDX_W-1:0] idx;
  } wrStrobe_t;

endpackage

// File: rtl/prg_bank_ctl.sv
module prg_bank_ctl
  import prg_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strobe
);

  logic inPageSpace;
  logic inCtlSpace;

  assign inPageSpace = (wrAddr[15:12] == PAGE_SPACE);
  assign inCtlSpace  = (wrAddr[15:12] == CTL_SPACE) && (wrAddr[11:8] < CTL_LIMIT);

  always_comb begin
    strobe        = '0;
    strobe.pageWr = wrEn && inPageSpace;
    strobe.ctlWr  = wrEn && inCtlSpace;
    strobe.idx    = wrAddr[IDX_W-1:0];
  end

endmodule

// File: rtl/prg_bank_dp.sv
module prg_bank_dp
  import prg_bank_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INNER_W = 6,
  parameter int OUTER_W = 2,
  localparam int BANK_W = INNER_W + OUTER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdHigh,
  output logic [BANK_W-1:0] prgBank,
  output logic              prgHit
);

  logic [DATA_W-1:0]  pageReg [REG_CNT];
  logic [INNER_W-1:0] page    [REG_CNT];
  logic [2:0]         modeReg;
  logic               winEnReg;
  logic [OUTER_W-1:0] outerReg;

  genvar gi;
  generate
    for (gi = 0; gi < REG_CNT; gi++) begin : g_page
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          pageReg[gi] <= '1;
        else if (strobe.pageWr && (strobe.idx == IDX_W'(gi)))
          pageReg[gi] <= wrData;
      end
      assign page[gi] = pageReg[gi][INNER_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      winEnReg <= 1'b0;
      outerReg <= '0;
    end else if (strobe.ctlWr) begin
      if (strobe.idx == IDX_W'(0)) begin
        modeReg  <= wrData[2:0];
        winEnReg <= wrData[DATA_W-1];
      end
      if (strobe.idx == IDX_W'(3))
        outerReg <= wrData[OUTER_W:1];
    end
  end

  pageSize_e          size;
  logic [INNER_W-1:0] topPage;
  logic [INNER_W-1:0] half16;
  logic [INNER_W-1:0] inner;
  logic               hit;

  assign size    = pageSize_e'(modeReg[1:0]);
  assign topPage = modeReg[2] ? page[3] : '1;
  assign half16  = rdHigh[1] ? topPage : page[1];

  always_comb begin
    inner = '0;
    hit   = 1'b0;
    if (rdHigh[2]) begin
      hit = 1'b1;
      unique case (size)
        SZ_32K:  inner = {topPage[INNER_W-3:0], rdHigh[1:0]};
        SZ_16K:  inner = {half16[INNER_W-2:0], rdHigh[0]};
        default: begin
          unique case (rdHigh[1:0])
            2'd0:    inner = page[0];
            2'd1:    inner = page[1];
            2'd2:    inner = page[2];
            default: inner = topPage;
          endcase
        end
      endcase
    end else if (rdHigh[1:0] == 2'b11 && winEnReg) begin
      hit = 1'b1;
      unique case (size)
        SZ_32K:  inner = {page[3][INNER_W-3:0], 2'b11};
        SZ_16K:  inner = {page[3][INNER_W-2:0], 1'b1};
        default: inner = page[3];
      endcase
    end
  end

  assign prgHit  = hit;
  assign prgBank = hit ? {outerReg, inner} : '0;

endmodule

// File: rtl/prg_bank_decoder.sv
module prg_bank_decoder
  import prg_bank_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INNER_W = 6,
  parameter int OUTER_W = 2,
  localparam int BANK_W = INNER_W + OUTER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BANK_W-1:0] prgBank,
  output logic              prgHit
);

  wrStrobe_t strobe;

  prg_bank_ctl i_ctl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  prg_bank_dp #(
    .DATA_W  (DATA_W),
    .INNER_W (INNER_W),
    .OUTER_W (OUTER_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .rdHigh  (rdAddr[15:13]),
    .prgBank (prgBank),
    .prgHit  (prgHit)
  );

endmodule

// File: rtl/prg_bank_chk.sv
module prg_bank_chk #(
  parameter int INNER_W = 6,
  parameter int BANK_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [15:0]       rdAddr,
  input logic [BANK_W-1:0] prgBank,
  input logic              prgHit
);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R9
  below_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr < 16'h6000) |-> (!prgHit && prgBank == '0));

  // R3
  upper_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[15] |-> prgHit);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(wrEn) && $stable(rdAddr)) |-> ($stable(prgBank) && $stable(prgHit)));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && rdAddr[15]) |->
      (prgBank[BANK_W-1:INNER_W] == '0 && prgBank[INNER_W-1:2] == '1
       && prgBank[1:0] == rdAddr[14:13]));

endmodule

bind prg_bank_decoder prg_bank_chk #(.INNER_W(INNER_W), .BANK_W(BANK_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdAddr  (rdAddr),
  .prgBank (prgBank),
  .prgHit  (prgHit)
);

// File: tb/test_prg_bank_decoder.sv
module test_prg_bank_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] rdAddr = '0;
  logic [7:0]  prgBank;
  logic        prgHit;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string curReq = "R1";

  // behavioural model state
  int mr[4];
  int mMode, mWin, mOuter;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_decoder i_prg_bank_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .prgBank(prgBank), .prgHit(prgHit)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mr[i] <= 255;
      mMode <= 0; mWin <= 0; mOuter <= 0;
    end else if (wrEn) begin
      int a, d;
      a = wrAddr; d = wrData;
      if ((a >> 12) == 8) mr[a % 4] <= d;
      if ((a >> 12) == 13 && ((a >> 8) % 16) < 6) begin
        if (a % 4 == 0) begin mMode <= d % 8; mWin <= d / 128; end
        if (a % 4 == 3) mOuter <= (d / 2) % 4;
      end
    end
  end

  function automatic void refMap(input int a, output int bk, output int hit);
    int sz, last, off, pg, s;
    sz = mMode % 4; if (sz == 3) sz = 2;
    last = mMode / 4;
    bk = 0; hit = 0;
    if (a < 'h6000) return;
    if (a < 'h8000) begin
      if (mWin == 0) return;
      hit = 1;
      if (sz == 0)      pg = (mr[3] * 4 + 3) % 64;
      else if (sz == 1) pg = (mr[3] * 2 + 1) % 64;
      else              pg = mr[3] % 64;
      bk = mOuter * 64 + pg;
      return;
    end
    hit = 1;
    off = a - 'h8000;
    s = off / 8192;
    if (sz == 0) begin
      pg = last ? mr[3] % 16 : 15;
      bk = mOuter * 64 + pg * 4 + s;
    end else if (sz == 1) begin
      if (off < 16384) pg = mr[1] % 32;
      else             pg = last ? mr[3] % 32 : 31;
      bk = mOuter * 64 + pg * 2 + s % 2;
    end else begin
      if (s < 3) pg = mr[s] % 64;
      else       pg = last ? mr[3] % 64 : 63;
      bk = mOuter * 64 + pg;
    end
  endfunction

  // compare every cycle, a quarter period after inputs change
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rstN && !done) begin
      int eb, eh;
      refMap(rdAddr, eb, eh);
      checks++;
      if (prgBank !== 8'(eb) || prgHit !== 1'(eh)) begin
        fails++;
        $display("FAIL %s addr=%h actual bank=%h hit=%b expected bank=%h hit=%0d",
                 curReq, rdAddr, prgBank, prgHit, 8'(eb), eh);
      end
    end
  end

  task automatic cyc(input bit we, input int wa, input int wd, input int ra);
    @(negedge clk);
    wrEn = we; wrAddr = 16'(wa); wrData = 8'(wd); rdAddr = 16'(ra);
  endtask

  task automatic sweep();
    for (int k = 0; k < 16; k++) cyc(0, 0, 0, (k << 12) | ((k % 2) ? 'hFFF : 0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; sweep();
    curReq = "R9"; cyc(0, 0, 0, 'h0000); cyc(0, 0, 0, 'h5FFF);
    curReq = "R8";
    cyc(1, 'h8000, 'h05, 'h8000); cyc(1, 'h8FF1, 'h12, 'hA000);
    cyc(1, 'h8002, 'h2A, 'hC000); cyc(1, 'h8003, 'h33, 'hE000);
    sweep();
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int o = 0; o < 4; o++) begin
          curReq = (m % 4 == 0) ? "R2" : (m % 4 == 1) ? "R3" : "R4";
          cyc(1, 'hD000, w * 128 + m, 'h6000);
          cyc(1, 'hD503, o * 2 + 'h20, 'h6000);
          sweep();
        end
      end
    end
    curReq = "R5";
    cyc(1, 'h8003, 'h3E, 'hE000); cyc(1, 'hD000, 'h04, 'hE000);
    cyc(1, 'hD000, 'h00, 'hE000); sweep();
    cyc(1, 'hD000, 'h05, 'hC000); sweep();
    cyc(1, 'hD000, 'h06, 'hE000); sweep();
    curReq = "R6";
    cyc(1, 'hD000, 'h80, 'h6000); cyc(1, 'hD000, 'h81, 'h7FFF);
    cyc(1, 'hD000, 'h82, 'h6000); cyc(1, 'hD000, 'h02, 'h6000); cyc(0, 0, 0, 'h6000);
    curReq = "R7";
    cyc(1, 'hD003, 'hFF, 'h8000); cyc(1, 'hD003, 'h02, 'hE000); cyc(0, 0, 0, 'hA000);
    curReq = "R8";
    cyc(1, 'h9000, 'h00, 'h8000); cyc(1, 'hD600, 'h87, 'h8000);
    cyc(1, 'hD001, 'h87, 'h8000); cyc(1, 'hD002, 'h87, 'h6000);
    cyc(1, 'h7000, 'h00, 'hC000); cyc(1, 'hE000, 'h00, 'hE000); sweep();
    curReq = "R10";
    cyc(1, 'hD000, 'h82, 'hC000);
    cyc(1, 'h8002, 'h11, 'hC000); cyc(0, 0, 0, 'hC000);
    cyc(1, 'h8003, 'h07, 'h6000); cyc(0, 0, 0, 'h6000);
    cyc(1, 'hD000, 'h02, 'h6000); cyc(0, 0, 0, 'h6000);
    curReq = "R1";
    rstN = 1'b0; cyc(0, 0, 0, 'h8000); cyc(0, 0, 0, 'h8000);
    @(negedge clk); rstN = 1'b1; sweep();
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule